// File: doc/BRIEF.md
# In-Place FFT Address Generator

This block produces every memory address that a single-butterfly, in-place radix-2 decimation-in-time engine needs for a 256-point complex transform. A controller picks the operating mode and sends increment and clear strobes. The block answers with three things: a read address for the data RAM, a write address for the data RAM, and a twiddle-coefficient address for the ROM. It also raises flags when an I/O pass, a stage or the whole transform has finished.

The data RAM holds one word per real or imaginary component. A word address is the point index shifted left by one, with bit 0 choosing the component (0 = real, 1 = imaginary). Samples are loaded in natural order. The transform works in place. Results are unloaded through a bit-reversed view of the point index, so they leave in natural frequency order. During the transform, each butterfly takes four increments. In each stage the two operand indices come from the 7-bit butterfly number by inserting a single bit at a position that moves one place lower per stage. The write address replays the read address after the butterfly pipeline latency.

Top module: `fft_agu`

## Requirements
- R1: After reset, all addresses are 0 and io_done_o, stage_done_o and fft_done_o are low.
- R2: Mode encoding is 0 = idle, 1 = load, 2 = unload, 3 = transform. In idle, all three addresses are 0 and increments have no effect.
- R3: In load mode, each increment advances a word counter by one. Both RAM addresses equal the counter's low 9 bits.
- R4: io_done_o is high once 512 increments have been counted in load or unload mode. Further increments leave the counter and the addresses unchanged.
- R5: In unload mode, the point bits [8:1] of both RAM addresses are the bit-reverse of counter bits [8:1]. Bit 0 follows counter bit 0.
- R6: In transform mode, let b be the 7-bit butterfly number and s the stage (0..7). Then index0 is b with a 0 inserted at bit 7-s, and index1 is the same with a 1 there. The four phases of each butterfly read B.re, B.im, A.re, A.im, where A = index0 and B = index1.
- R7: The twiddle address is the reverse of the s-bit group number (b >> (7-s)), multiplied by 2^(7-s). It is 0 throughout stage 0 and in the non-transform modes.
- R8: In transform mode, the write address equals the read address from 5 clock cycles earlier.
- R9: stage_done_o is a one-cycle pulse, issued after the increment that completes the last phase of butterfly 127. The stage then advances by one.
- R10: fft_done_o goes high with the eighth stage_done_o pulse. It stays high, and further transform increments leave the read address unchanged.
- R11: A clear returns the counter, the stage and all flags to zero. Without an increment or a mode change, the read address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode: 0 idle, 1 load, 2 unload, 3 transform |
| inc_i | input | 1 | Advance one word or one butterfly phase |
| clr_i | input | 1 | Clear counter, stage and flags |
| rd_addr_o | output | 9 | Data RAM read word address |
| wr_addr_o | output | 9 | Data RAM write word address |
| rom_addr_o | output | 7 | Twiddle ROM address |
| io_done_o | output | 1 | Load/unload pass complete |
| stage_done_o | output | 1 | One-cycle end-of-stage pulse |
| fft_done_o | output | 1 | All eight stages complete |

## Verification
The assertions check several rules on every cycle:
- stage_done_o stays a single-cycle pulse;
- fft_done_o stays high until a clear;
- the clear clears the flags;
- the read address holds while no increment arrives;
- the address freezes after io_done_o or fft_done_o;
- the component bit alternates on each transform increment.

Some behaviour can only be shown by the bench scenarios, which compare the outputs against index arithmetic computed independently:
- the actual operand indices for every stage, including where the inserted bit moves;
- the bit-reversed unload order;
- the twiddle sequence;
- the five-cycle skew of the write address.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;
    localparam int LOG2N = 8;
    localparam int PW    = LOG2N;
    localparam int AW    = LOG2N + 1;
    localparam int BW    = LOG2N - 1;
    localparam int SW    = $clog2(LOG2N);

    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_LOAD   = 2'd1,
        M_UNLOAD = 2'd2,
        M_XFORM  = 2'd3
    } mode_t;

    function automatic logic [PW-1:0] rev_point(input logic [PW-1:0] v);
        logic [PW-1:0] r;
        for (int i = 0; i < PW; i++) r[i] = v[PW-1-i];
        return r;
    endfunction

    function automatic logic [PW-1:0] put_bit(input logic [BW-1:0] b,
                                              input logic [SW-1:0] s,
                                              input logic v);
        logic [PW-1:0] r;
        int p;
        p = BW - int'(s);
        for (int i = 0; i < PW; i++) begin
            if (i < p)       r[i] = b[i];
            else if (i == p) r[i] = v;
            else             r[i] = b[i-1];
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] twiddle(input logic [BW-1:0] b,
                                              input logic [SW-1:0] s);
        logic [BW-1:0] k;
        int p;
        p = BW - int'(s);
        k = '0;
        for (int i = 0; i < BW; i++) begin
            if (i < int'(s)) k[BW-1-i] = b[p+i];
        end
        return k;
    endfunction
endpackage

// File: rtl/fft_agu_counter.sv
module fft_agu_counter
    import fft_agu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic          inc,
    input  logic          clr,
    output logic [AW:0]   cnt,
    output logic [SW-1:0] stage,
    output logic          stage_done,
    output logic          fft_done
);
    localparam logic [SW-1:0] LAST_STAGE = SW'(LOG2N - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt        <= '0;
            stage      <= '0;
            stage_done <= 1'b0;
            fft_done   <= 1'b0;
        end else begin
            stage_done <= 1'b0;
            if (inc) begin
                case (mode)
                    M_LOAD, M_UNLOAD: begin
                        if (!cnt[AW]) cnt <= cnt + 1'b1;
                    end
                    M_XFORM: begin
                        if (!fft_done) begin
                            if (cnt[AW-1:0] == '1) begin
                                cnt        <= '0;
                                stage_done <= 1'b1;
                                stage      <= stage + 1'b1;
                                if (stage == LAST_STAGE) fft_done <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fft_agu_index.sv
module fft_agu_index
    import fft_agu_pkg::*;
(
    input  mode_t         mode,
    input  logic [AW-1:0] word,
    input  logic [SW-1:0] stage,
    output logic [AW-1:0] rd_addr,
    output logic [BW-1:0] rom_addr
);
    logic [BW-1:0] bfly;
    logic [1:0]    phase;
    logic [PW-1:0] idx_a, idx_b;

    assign bfly  = word[AW-1:2];
    assign phase = word[1:0];

    always_comb begin
        idx_a    = put_bit(bfly, stage, 1'b0);
        idx_b    = put_bit(bfly, stage, 1'b1);
        rd_addr  = '0;
        rom_addr = '0;
        case (mode)
            M_LOAD:   rd_addr = word;
            M_UNLOAD: rd_addr = {rev_point(word[AW-1:1]), word[0]};
            M_XFORM: begin
                rd_addr  = {(phase[1] ? idx_a : idx_b), phase[0]};
                rom_addr = twiddle(bfly, stage);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fft_agu_skew.sv
module fft_agu_skew
    import fft_agu_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    logic [AW-1:0] pipe [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         pipe[g] <= '0;
            else if (g == 0) pipe[g] <= din;
            else             pipe[g] <= pipe[(g == 0) ? 0 : g-1];
        end
    end

    assign dout = pipe[LAT-1];
endmodule

// File: rtl/fft_agu.sv
module fft_agu
    import fft_agu_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_i,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [BW-1:0] rom_addr_o,
    output logic          io_done_o,
    output logic          stage_done_o,
    output logic          fft_done_o
);
    mode_t         mode;
    logic [AW:0]   cnt;
    logic [SW-1:0] stage;
    logic [AW-1:0] skewed;

    assign mode = mode_t'(mode_i);

    fft_agu_counter u_cnt (
        .clk(clk), .rst(rst), .mode(mode), .inc(inc_i), .clr(clr_i),
        .cnt(cnt), .stage(stage), .stage_done(stage_done_o), .fft_done(fft_done_o)
    );

    fft_agu_index u_idx (
        .mode(mode), .word(cnt[AW-1:0]), .stage(stage),
        .rd_addr(rd_addr_o), .rom_addr(rom_addr_o)
    );

    fft_agu_skew #(.LAT(LAT)) u_skew (
        .clk(clk), .rst(rst), .din(rd_addr_o), .dout(skewed)
    );

    assign io_done_o = cnt[AW];
    assign wr_addr_o = (mode == M_XFORM) ? skewed : rd_addr_o;
endmodule

// File: rtl/fft_agu_checks.sv
module fft_agu_checks
    import fft_agu_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_i,
    input logic          inc_i,
    input logic          clr_i,
    input logic [AW-1:0] rd_addr_o,
    input logic          io_done_o,
    input logic          stage_done_o,
    input logic          fft_done_o
);
    assert_stage_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        stage_done_o |=> !stage_done_o);

    assert_fft_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (fft_done_o && !clr_i) |=> fft_done_o);

    assert_fft_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        (fft_done_o && !clr_i && mode_i == 2'd3) |=>
        (mode_i != 2'd3 || $stable(rd_addr_o)));

    assert_io_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (io_done_o && !clr_i && (mode_i == 2'd1 || mode_i == 2'd2)) |=>
        (!$stable(mode_i) || $stable(rd_addr_o)));

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!io_done_o && !stage_done_o && !fft_done_o));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !clr_i) |=> (!$stable(mode_i) || $stable(rd_addr_o)));

    assert_phase_alt_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd3 && inc_i && !clr_i && !fft_done_o) |=>
        (mode_i != 2'd3 || rd_addr_o[0] != $past(rd_addr_o[0])));
endmodule

bind fft_agu fft_agu_checks u_checks (
    .clk(clk), .rst(rst), .mode_i(mode_i), .inc_i(inc_i), .clr_i(clr_i),
    .rd_addr_o(rd_addr_o), .io_done_o(io_done_o),
    .stage_done_o(stage_done_o), .fft_done_o(fft_done_o)
);

// File: tb/fft_agu_test.sv
module fft_agu_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_i;
    logic       inc_i, clr_i;
    logic [8:0] rd_addr_o, wr_addr_o;
    logic [6:0] rom_addr_o;
    logic       io_done_o, stage_done_o, fft_done_o;

    int n_cmp = 0, n_bad = 0;

    // model state
    int m_cnt, m_stage, m_fft_done, m_sd;
    int hist [$];

    always #4 clk = ~clk;

    fft_agu uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .inc_i(inc_i), .clr_i(clr_i),
        .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o), .rom_addr_o(rom_addr_o),
        .io_done_o(io_done_o), .stage_done_o(stage_done_o), .fft_done_o(fft_done_o)
    );

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int brev(input int v, input int bits);
        int r = 0;
        for (int i = 0; i < bits; i++) if ((v >> i) & 1) r |= 1 << (bits - 1 - i);
        return r;
    endfunction

    function automatic int exp_rd(input int m, input int cnt, input int st);
        int w, b, ph, p, i0, i1;
        w = cnt % 512;
        case (m)
            1: return w;
            2: return (brev(w >> 1, 8) << 1) | (w & 1);
            3: begin
                b = w >> 2; ph = w & 3; p = 7 - st;
                i0 = ((b >> p) << (p + 1)) | (b & ((1 << p) - 1));
                i1 = i0 + (1 << p);
                return (((ph >= 2) ? i0 : i1) << 1) | (ph & 1);
            end
            default: return 0;
        endcase
    endfunction

    function automatic int exp_rom(input int m, input int cnt, input int st);
        int b, p;
        if (m != 3) return 0;
        b = (cnt % 512) >> 2; p = 7 - st;
        return brev(b >> p, st) << p;
    endfunction

    task automatic tick(input bit inc, input bit clr, input int m);
        inc_i = inc; clr_i = clr; mode_i = 2'(m);
        @(posedge clk);
        m_sd = 0;
        if (clr) begin
            m_cnt = 0; m_stage = 0; m_fft_done = 0;
        end else if (inc) begin
            if (m == 1 || m == 2) begin
                if (m_cnt < 512) m_cnt++;
            end else if (m == 3 && !m_fft_done) begin
                if (m_cnt == 511) begin
                    m_cnt = 0; m_sd = 1;
                    if (m_stage == 7) m_fft_done = 1;
                    m_stage = (m_stage + 1) % 8;
                end else m_cnt++;
            end
        end
        @(negedge clk);
        hist.push_back(int'(rd_addr_o));
    endtask

    task automatic check_all(input int m, input int in_mode_cycles);
        if (m == 1) check("R3 load rd", rd_addr_o, exp_rd(m, m_cnt, m_stage));
        else if (m == 2) check("R5 unload rd", rd_addr_o, exp_rd(m, m_cnt, m_stage));
        else if (m == 3) check("R6 xform rd", rd_addr_o, exp_rd(m, m_cnt, m_stage));
        else check("R2 idle rd", rd_addr_o, 0);
        check("R7 rom", rom_addr_o, exp_rom(m, m_cnt, m_stage));
        if (m == 3) begin
            if (in_mode_cycles >= 5)
                check("R8 wr skew", wr_addr_o, hist[hist.size() - 6]);
        end else check("R3 wr follows rd", wr_addr_o, rd_addr_o);
        check("R4 io_done", io_done_o, (m_cnt == 512) ? 1 : 0);
        check("R9 stage_done", stage_done_o, m_sd);
        check("R10 fft_done", fft_done_o, m_fft_done);
    endtask

    task automatic run(input int m, input int cycles, input int inc_pct);
        for (int c = 1; c <= cycles; c++) begin
            tick(($urandom % 100) < inc_pct, 1'b0, m);
            check_all(m, c);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; inc_i = 0; clr_i = 0; mode_i = 0;
        m_cnt = 0; m_stage = 0; m_fft_done = 0; m_sd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rd", rd_addr_o, 0);
        check("R1 wr", wr_addr_o, 0);
        check("R1 rom", rom_addr_o, 0);
        check("R1 flags", {io_done_o, stage_done_o, fft_done_o}, 0);

        // R2 idle ignores increments
        run(0, 20, 100);

        // R3 load with random gaps, then saturation (R4)
        tick(0, 1, 1); check_all(1, 1);
        run(1, 900, 75);
        check("R4 io_done after 512", io_done_o, 1);
        run(1, 20, 100);

        // R11 clear
        tick(0, 1, 2);
        check("R11 cleared io_done", io_done_o, 0);
        check("R5 first unload addr", rd_addr_o, 0);
        tick(1, 0, 2);
        check("R5 word1 is imag of point0", rd_addr_o, 1);
        tick(1, 0, 2);
        check("R5 point1 reversed to 128", rd_addr_o, 256);
        run(2, 700, 90);

        // transform, continuous increments
        tick(0, 1, 3);
        check("R6 first read is B.re index1=128", rd_addr_o, 256);
        check("R7 stage0 rom zero", rom_addr_o, 0);
        run(3, 4100, 100);
        check("R10 fft_done set", fft_done_o, 1);
        run(3, 30, 100);

        // transform, random increments
        tick(0, 1, 3);
        check("R11 cleared fft_done", fft_done_o, 0);
        run(3, 6000, 80);

        // R11 hold without inc
        begin
            int held;
            held = rd_addr_o;
            for (int i = 0; i < 8; i++) tick(0, 0, 3);
            check("R11 hold", rd_addr_o, held);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule